// File: doc/BRIEF.md
# Split Static/Dynamic Memory Access Sequencer

This block sits on the memory side of a processor core. It carries out one 16-bit word read or word write at a time. The caller presents a byte address, write data and a return-state code, then pulses a read or write request while the block is idle. The block turns the byte address into a word address by dropping bit 0. It then picks one of two paths by comparing the byte address with a fixed boundary parameter. The default boundary is 40960, so the bottom 40 KB goes to on-chip static RAM. Every address at or above the boundary goes to an external dynamic-RAM controller.

Static RAM accesses use a single-cycle strobe, and the data is taken on the following cycle. Dynamic RAM accesses use a request/busy/ready handshake:

- The enable is held until the controller reports busy.
- A read then waits for a one-cycle ready pulse that carries the data.
- A write waits for busy to clear.

When an access ends, the block gives a one-cycle completion pulse. The pulse comes with the caller's return code, so the caller's own state machine can resume where it left off.

States, named in this brief:

- IDLE accepts a request. A read goes to RD_REQ and a write goes to WR_REQ.
- RD_REQ moves to RD_WAIT at once for static RAM, or when busy is seen for dynamic RAM.
- RD_WAIT moves to IDLE at once for static RAM, or on the ready pulse for dynamic RAM.
- WR_REQ moves to WR_WAIT at once for static RAM, or when busy is seen for dynamic RAM.
- WR_WAIT moves to IDLE at once for static RAM, or when busy is low for dynamic RAM.

Top module: `split_mem_seq`

## Requirements
- R1: After reset, `idle` is 1, and `done`, `sram_rd`, `sram_wr`, `sdram_rd_en`, `sdram_wr_en` and `sdram_waiting` are all 0.
- R2: A request whose byte address is below `SDRAM_BASE` (default 40960) uses the static RAM port only. A request at or above it uses the dynamic RAM port only. The word address driven is the byte address shifted right by one.
- R3: A static RAM read raises `sram_rd` for exactly the one cycle after acceptance. It captures `sram_rdata` on the next edge and raises `done` 2 cycles after the accepting edge, with the captured word on `rsp_rdata`.
- R4: A static RAM write raises `sram_wr`, with the address and data, for exactly the one cycle after acceptance, and raises `done` 2 cycles after the accepting edge.
- R5: A dynamic RAM read holds `sdram_rd_en` from the cycle after acceptance until the edge that samples `sdram_busy` high, and then drops it. It completes when `sdram_rd_ready` is sampled high, capturing `sdram_rdata`, and `done` appears one cycle after that sample.
- R6: A dynamic RAM write holds `sdram_wr_en`, with the address and data, until `sdram_busy` is sampled high. It then waits until `sdram_busy` is sampled low, and `done` appears one cycle after that sample.
- R7: `sdram_waiting` is 1 for every cycle from acceptance of a dynamic RAM access until its completion, and is 0 while `done` is 1.
- R8: `done` is a one-cycle pulse, and while it is 1, `rsp_ret` equals the `req_ret` given with the completed request.
- R9: A request is accepted only in IDLE. Requests that arrive in any other state are dropped with no access and no `done`. If `req_rd` and `req_wr` are both 1 in IDLE, the read is taken and the write is dropped.
- R10: `sdram_rd_en` and `sdram_wr_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rd | input | 1 | Read request pulse, taken when idle |
| req_wr | input | 1 | Write request pulse, taken when idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Word to write |
| req_ret | input | RET_W | Return-state code to hand back on completion |
| idle | output | 1 | Sequencer is in IDLE and can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word read by the last completed read |
| rsp_ret | output | RET_W | Return code of the completed request |
| sram_addr | output | ADDR_W-1 | Static RAM word address |
| sram_wdata | output | DATA_W | Static RAM write data |
| sram_rd | output | 1 | Static RAM read strobe |
| sram_wr | output | 1 | Static RAM write strobe |
| sram_rdata | input | DATA_W | Static RAM read data, registered one cycle after the strobe |
| sdram_addr | output | ADDR_W-1 | Dynamic RAM controller word address |
| sdram_wdata | output | DATA_W | Dynamic RAM controller write data |
| sdram_rd_en | output | 1 | Dynamic RAM read enable |
| sdram_wr_en | output | 1 | Dynamic RAM write enable |
| sdram_busy | input | 1 | Controller has taken a request and is working on it |
| sdram_rd_ready | input | 1 | One-cycle pulse marking valid read data |
| sdram_rdata | input | DATA_W | Dynamic RAM read data |
| sdram_waiting | output | 1 | A dynamic RAM access is outstanding |

## Verification
The bench asserts a request so that a known rising edge accepts it, and it records that edge number in the scoreboard entry. A static RAM access must complete exactly 2 edges later. With the stub's busy window of 4 cycles, a dynamic RAM access must complete 6 edges later: one edge for the stub to raise busy, four busy cycles, and one edge for the sequencer to see ready or busy low. The monitor samples on the falling edge. It compares the measured edge distance, the return code and the read word against the popped entry. The strobe and enable levels are probed on the falling edges just after acceptance, one and two edges in, where R3 to R6 fix their values.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } seq_state_t;

endpackage

// File: rtl/mseq_region.sv
module mseq_region #(
    parameter int ADDR_W     = 25,
    parameter int SDRAM_BASE = 40960
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [ADDR_W-2:0] word_addr,
    output logic              is_ext
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(SDRAM_BASE);

    always_comb begin
        word_addr = byte_addr[ADDR_W-1:1];
        is_ext    = (byte_addr >= BASE_V);
    end
endmodule

// File: rtl/mseq_fsm.sv
module mseq_fsm
    import mseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_rd,
    input  logic       start_wr,
    input  logic       ext_q,
    input  logic       ext_busy,
    input  logic       ext_ready,
    output seq_state_t state,
    output logic       accept,
    output logic       finish,
    output logic       finish_rd
);
    seq_state_t state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start_rd)      state_n = ST_RD_REQ;
                else if (start_wr) state_n = ST_WR_REQ;
            end
            ST_RD_REQ:  if (!ext_q || ext_busy)   state_n = ST_RD_WAIT;
            ST_RD_WAIT: if (!ext_q || ext_ready)  state_n = ST_IDLE;
            ST_WR_REQ:  if (!ext_q || ext_busy)   state_n = ST_WR_WAIT;
            ST_WR_WAIT: if (!ext_q || !ext_busy)  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state == ST_IDLE) && (start_rd || start_wr);
        finish    = (state == ST_RD_WAIT || state == ST_WR_WAIT) && (state_n == ST_IDLE);
        finish_rd = finish && (state == ST_RD_WAIT);
    end
endmodule

// File: rtl/mseq_datapath.sv
module mseq_datapath #(
    parameter int ADDR_W = 25,
    parameter int DATA_W = 16,
    parameter int RET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              finish,
    input  logic              finish_rd,
    input  logic [ADDR_W-2:0] word_in,
    input  logic              ext_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [RET_W-1:0]  ret_in,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic [DATA_W-1:0] sdram_rdata,
    output logic [ADDR_W-2:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              ext_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic [RET_W-1:0]  resume_q,
    output logic              done_q
);
    logic [RET_W-1:0] ret_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            ext_q   <= 1'b0;
            ret_q   <= '0;
        end else if (accept) begin
            addr_q  <= word_in;
            wdata_q <= wdata_in;
            ext_q   <= ext_in;
            ret_q   <= ret_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            resume_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) resume_q <= ret_q;
            if (finish_rd) rdata_q <= ext_q ? sdram_rdata : sram_rdata;
        end
    end
endmodule

// File: rtl/split_mem_seq.sv
module split_mem_seq
    import mseq_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int DATA_W     = 16,
    parameter int RET_W      = 4,
    parameter int SDRAM_BASE = 40960
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RET_W-1:0]  req_ret,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [RET_W-1:0]  rsp_ret,
    output logic [ADDR_W-2:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_rd,
    output logic              sram_wr,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic [ADDR_W-2:0] sdram_addr,
    output logic [DATA_W-1:0] sdram_wdata,
    output logic              sdram_rd_en,
    output logic              sdram_wr_en,
    input  logic              sdram_busy,
    input  logic              sdram_rd_ready,
    input  logic [DATA_W-1:0] sdram_rdata,
    output logic              sdram_waiting
);
    seq_state_t        state;
    logic              accept, finish, finish_rd;
    logic [ADDR_W-2:0] word_in, addr_q;
    logic              ext_in, ext_q;
    logic [DATA_W-1:0] wdata_q;

    mseq_region #(.ADDR_W(ADDR_W), .SDRAM_BASE(SDRAM_BASE)) u_region (
        .byte_addr (req_addr),
        .word_addr (word_in),
        .is_ext    (ext_in)
    );

    mseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (req_rd),
        .start_wr  (req_wr),
        .ext_q     (ext_q),
        .ext_busy  (sdram_busy),
        .ext_ready (sdram_rd_ready),
        .state     (state),
        .accept    (accept),
        .finish    (finish),
        .finish_rd (finish_rd)
    );

    mseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RET_W(RET_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .finish      (finish),
        .finish_rd   (finish_rd),
        .word_in     (word_in),
        .ext_in      (ext_in),
        .wdata_in    (req_wdata),
        .ret_in      (req_ret),
        .sram_rdata  (sram_rdata),
        .sdram_rdata (sdram_rdata),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .ext_q       (ext_q),
        .rdata_q     (rsp_rdata),
        .resume_q    (rsp_ret),
        .done_q      (done)
    );

    // Output decode: strobes and enables follow the state and the latched region.
    always_comb begin
        sram_addr     = addr_q;
        sdram_addr    = addr_q;
        sram_wdata    = wdata_q;
        sdram_wdata   = wdata_q;
        sram_rd       = 1'b0;
        sram_wr       = 1'b0;
        sdram_rd_en   = 1'b0;
        sdram_wr_en   = 1'b0;
        idle          = 1'b0;
        sdram_waiting = 1'b0;
        unique case (state)
            ST_IDLE:    idle = 1'b1;
            ST_RD_REQ: begin
                sdram_rd_en   = ext_q;
                sram_rd       = !ext_q;
                sdram_waiting = ext_q;
            end
            ST_WR_REQ: begin
                sdram_wr_en   = ext_q;
                sram_wr       = !ext_q;
                sdram_waiting = ext_q;
            end
            ST_RD_WAIT, ST_WR_WAIT: sdram_waiting = ext_q;
            default:    idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/split_mem_seq_chk.sv
module split_mem_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic idle,
    input logic done,
    input logic sram_rd,
    input logic sram_wr,
    input logic sdram_rd_en,
    input logic sdram_wr_en,
    input logic sdram_busy,
    input logic sdram_waiting
);
    AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdram_rd_en && sdram_wr_en)); // R10

    AST_SRAM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_rd || sram_wr) |=> !(sram_rd || sram_wr)); // R3

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_rd_en && !sdram_busy) |=> sdram_rd_en); // R5

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_wr_en && !sdram_busy) |=> sdram_wr_en); // R6

    AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sdram_waiting); // R7

    AST_WAIT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdram_waiting) |-> done); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(sram_rd || sram_wr || sdram_rd_en || sdram_wr_en)); // R2
endmodule

bind split_mem_seq split_mem_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle          (idle),
    .done          (done),
    .sram_rd       (sram_rd),
    .sram_wr       (sram_wr),
    .sdram_rd_en   (sdram_rd_en),
    .sdram_wr_en   (sdram_wr_en),
    .sdram_busy    (sdram_busy),
    .sdram_waiting (sdram_waiting)
);

// File: tb/tb_split_mem_seq.sv
module tb_split_mem_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 25;
    localparam int DATA_W     = 16;
    localparam int RET_W      = 4;
    localparam int BASE       = 40960;
    localparam int SD_LAT     = 4;
    localparam int SRAM_CYC   = 2;
    localparam int EXT_CYC    = SD_LAT + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rd = 1'b0, req_wr = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [RET_W-1:0]  req_ret = '0;
    logic idle, done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [RET_W-1:0]  rsp_ret;
    logic [ADDR_W-2:0] sram_addr, sdram_addr;
    logic [DATA_W-1:0] sram_wdata, sdram_wdata;
    logic sram_rd, sram_wr, sdram_rd_en, sdram_wr_en;
    logic [DATA_W-1:0] sram_rdata, sdram_rdata;
    logic sdram_busy, sdram_rd_ready, sdram_waiting;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RET_W(RET_W), .SDRAM_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ret(req_ret), .idle(idle), .done(done),
        .rsp_rdata(rsp_rdata), .rsp_ret(rsp_ret), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rd(sram_rd), .sram_wr(sram_wr),
        .sram_rdata(sram_rdata), .sdram_addr(sdram_addr), .sdram_wdata(sdram_wdata),
        .sdram_rd_en(sdram_rd_en), .sdram_wr_en(sdram_wr_en), .sdram_busy(sdram_busy),
        .sdram_rd_ready(sdram_rd_ready), .sdram_rdata(sdram_rdata),
        .sdram_waiting(sdram_waiting)
    );

    // Static RAM model: registered read one cycle after the strobe
    logic [DATA_W-1:0] sram_m [int];
    always @(posedge clk) begin
        if (sram_wr) sram_m[int'(sram_addr)] = sram_wdata;
        if (sram_rd) sram_rdata <= sram_m.exists(int'(sram_addr)) ? sram_m[int'(sram_addr)] : '0;
    end

    // Dynamic RAM controller stub: busy for SD_LAT cycles, then ready pulse on reads
    logic [DATA_W-1:0] sdram_m [int];
    int   sd_cnt;
    logic sd_is_rd;
    int   sd_a;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdram_busy <= 1'b0; sdram_rd_ready <= 1'b0; sdram_rdata <= '0;
            sd_cnt <= 0; sd_is_rd <= 1'b0; sd_a <= 0;
        end else begin
            sdram_rd_ready <= 1'b0;
            if (!sdram_busy) begin
                if (sdram_rd_en || sdram_wr_en) begin
                    sdram_busy <= 1'b1;
                    sd_cnt     <= SD_LAT - 1;
                    sd_is_rd   <= sdram_rd_en;
                    sd_a       <= int'(sdram_addr);
                    if (sdram_wr_en) sdram_m[int'(sdram_addr)] = sdram_wdata;
                end
            end else if (sd_cnt == 0) begin
                sdram_busy <= 1'b0;
                if (sd_is_rd) begin
                    sdram_rd_ready <= 1'b1;
                    sdram_rdata    <= sdram_m.exists(sd_a) ? sdram_m[sd_a] : '0;
                end
            end else begin
                sd_cnt <= sd_cnt - 1;
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    typedef struct {
        bit               rd;
        bit               ext;
        logic [DATA_W-1:0] data;
        logic [RET_W-1:0]  ret;
        int               accept;
    } exp_t;
    exp_t exp_q[$];
    logic [DATA_W-1:0] shadow [int];

    // Driver: waits for idle, pulses the request for one cycle, pushes the expectation
    task automatic drive(input bit rd, input bit wr, input int addr,
                         input logic [DATA_W-1:0] wdat, input logic [RET_W-1:0] ret);
        exp_t e;
        while (!idle) @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = ADDR_W'(addr); req_wdata = wdat; req_ret = ret;
        e.rd = rd; e.ext = (addr >= BASE); e.ret = ret; e.accept = cyc + 1;
        if (rd) e.data = shadow.exists(addr >> 1) ? shadow[addr >> 1] : '0;
        else begin e.data = wdat; shadow[addr >> 1] = wdat; end
        exp_q.push_back(e);
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    // Monitor: pops one expectation per completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                string tg;
                e = exp_q.pop_front();
                tg = e.rd ? (e.ext ? "R5 read latency" : "R3 read latency")
                          : (e.ext ? "R6 write latency" : "R4 write latency");
                chk(tg, 32'(cyc - e.accept), e.ext ? EXT_CYC : SRAM_CYC);
                chk("R8 return code", 32'(rsp_ret), 32'(e.ret));
                chk("R7 waiting low at done", 32'(sdram_waiting), 32'd0);
                if (e.rd) chk(e.ext ? "R5 read data" : "R3 read data",
                              32'(rsp_rdata), 32'(e.data));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle", 32'(idle), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 strobes", 32'({sram_rd, sram_wr, sdram_rd_en, sdram_wr_en}), 32'd0);
        chk("R1 waiting", 32'(sdram_waiting), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", 32'(idle), 32'd1);

        // Static RAM write, strobe for one cycle
        drive(0, 1, 'h0010, 16'h1111, 4'd3);
        chk("R4 sram_wr strobe", 32'(sram_wr), 32'd1);
        chk("R2 word address", 32'(sram_addr), 32'h0008);
        chk("R2 no sdram enable", 32'(sdram_wr_en), 32'd0);
        @(negedge clk);
        chk("R4 sram_wr dropped", 32'(sram_wr), 32'd0);

        // Static RAM read
        drive(1, 0, 'h0010, 16'h0, 4'd5);
        chk("R3 sram_rd strobe", 32'(sram_rd), 32'd1);
        @(negedge clk);
        chk("R3 sram_rd dropped", 32'(sram_rd), 32'd0);

        // Dynamic RAM write
        drive(0, 1, 'h10000, 16'h2222, 4'd7);
        chk("R6 wr_en before busy", 32'(sdram_wr_en), 32'd1);
        chk("R10 rd_en low during write", 32'(sdram_rd_en), 32'd0);
        chk("R2 sdram word address", 32'(sdram_addr), 32'h8000);
        chk("R7 waiting during write", 32'(sdram_waiting), 32'd1);
        @(negedge clk);
        chk("R6 wr_en held on busy edge", 32'(sdram_wr_en), 32'd1);
        @(negedge clk);
        chk("R6 wr_en dropped in wait", 32'(sdram_wr_en), 32'd0);

        // Dynamic RAM read
        drive(1, 0, 'h10000, 16'h0, 4'd9);
        chk("R5 rd_en before busy", 32'(sdram_rd_en), 32'd1);
        chk("R2 no sram strobe", 32'(sram_rd), 32'd0);
        @(negedge clk);
        chk("R5 rd_en held on busy edge", 32'(sdram_rd_en), 32'd1);
        @(negedge clk);
        chk("R5 rd_en dropped in wait", 32'(sdram_rd_en), 32'd0);
        chk("R7 waiting in read wait", 32'(sdram_waiting), 32'd1);

        // Boundary on both sides
        drive(0, 1, BASE - 2, 16'h3333, 4'd1);
        drive(0, 1, BASE,     16'h4444, 4'd2);
        drive(1, 0, BASE - 2, 16'h0, 4'd4);
        drive(1, 0, BASE,     16'h0, 4'd6);

        // R9: request while busy is dropped
        drive(0, 1, 'h0020, 16'h6666, 4'd8);
        drive(0, 1, 'h12000, 16'h5555, 4'd10);
        req_wr = 1'b1; req_addr = ADDR_W'('h0020); req_wdata = 16'hDEAD; req_ret = 4'd15;
        @(negedge clk);
        req_wr = 1'b0;
        drive(1, 0, 'h0020, 16'h0, 4'd11);

        // R9: simultaneous read and write in idle, read wins
        drive(1, 1, 'h0010, 16'hBEEF, 4'd12);
        drive(1, 0, 'h0010, 16'h0, 4'd13);

        // Several return codes on dynamic RAM reads (R8)
        for (int i = 0; i < 4; i++) drive(1, 0, 'h12000, 16'h0, 4'(i + 2));

        while (exp_q.size() != 0 || !idle) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 no pending expectations", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule